// File: doc/BRIEF.md
# Register write-access authentication gate

This block sits in front of a small bank of 32-bit general-purpose control words and decides, per bus write, whether that write may land. Each write arrives with a requester domain number, a privileged/user flag and a secure/non-secure flag. A single policy word, kept at address 0, holds the domain allow-list and two permission enables: one admits user-mode writers and one admits non-secure writers. It also holds three one-way lock bits. Each lock bit freezes one group of policy fields, or freezes a configurable subset of the bank.

A write to a bank word is accepted only when all three checks pass: the domain is on the allow-list, the privilege level is admitted and the security state is admitted. The policy word itself only requires the privilege and security checks, and it changes only in the fields whose lock is still open. The cycle after every write, the block raises exactly one of two one-cycle pulses: accepted or refused. Reads are combinational and never blocked. Bus protocol conversion is left to a wrapper, and so is forwarding the refusal pulse onto an interconnect.

Top module: `wr_auth_gate`

## Requirements
- R1: After reset the policy word reads 0x0000_0000, every bank word reads 0, and both `wr_grant` and `wr_err` are low.
- R2: Policy bits 31:16 are the allow-list. Bit 16+n admits domain n. A bank write from a domain whose bit is clear is refused: the word keeps its value and `wr_err` pulses.
- R3: Policy bit 8 admits user writers. While it is 0, any write with `wr_priv`=0 is refused, to the bank or to the policy word. While it is 1, user and privileged writers both pass this check.
- R4: Policy bit 9 admits non-secure writers. While it is 0, any write with `wr_sec`=0 is refused, to the bank or to the policy word. While it is 1, both security states pass.
- R5: Policy bit 11 is a one-way lock. Once it is set, bits 11, 9 and 8 no longer change.
- R6: Policy bit 15 is a one-way lock. Once it is set, bit 15 and bits 31:16 no longer change.
- R7: Policy bit 7 is a one-way lock. Once it is set, writes to the bank words selected by `PROT_MASK` are refused (default: addresses 1 to 4). The other bank words stay writable.
- R8: An accepted policy write updates every field whose lock was open before the write. A write that sets a lock together with new values for the fields that lock guards applies those values. Bits 14:12, 10 and 6:0 always read 0.
- R9: For each write, exactly one of `wr_grant` and `wr_err` is high in the following cycle, for that cycle only. Neither is high after a cycle without a write. Writes to addresses above `N_WORDS` are refused.
- R10: `rd_data` follows `rd_addr` combinationally. Address 0 returns the policy word, addresses 1..`N_WORDS` return the bank words, and higher addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | AW | Write address: 0 is the policy word, 1..N_WORDS are bank words |
| wr_data | input | 32 | Write data |
| wr_dom | input | DOM_W | Requester domain number |
| wr_priv | input | 1 | 1 = privileged requester, 0 = user |
| wr_sec | input | 1 | 1 = secure requester, 0 = non-secure |
| rd_addr | input | AW | Read address |
| rd_data | output | 32 | Read data |
| wr_grant | output | 1 | One-cycle pulse: the previous write was accepted |
| wr_err | output | 1 | One-cycle pulse: the previous write was refused |

## Verification
Two things can happen in the same clock edge: a lock bit is being set, and the fields that lock guards are being rewritten. The bench provokes this with a single policy write that sets the allow-list lock and carries a new allow-list. It then judges by reading back the policy word, which must show the new list and the lock set. A second write follows that tries to change the list and clear the lock; it must be accepted and change nothing. The same check is applied to the trust lock, with the two enables in the same write.

// File: rtl/wag_pkg.sv
`timescale 1ns/1ps
package wag_pkg;
   localparam int unsigned CW_W          = 32;
   localparam int unsigned CFG_LOCK_BIT  = 7;
   localparam int unsigned USER_EN_BIT   = 8;
   localparam int unsigned NS_EN_BIT     = 9;
   localparam int unsigned TZ_LOCK_BIT   = 11;
   localparam int unsigned LIST_LOCK_BIT = 15;
   localparam int unsigned ALLOW_LSB     = 16;
   localparam int unsigned ALLOW_W       = 16;

   typedef struct packed {
      logic [ALLOW_W-1:0] allow;
      logic               list_lock;
      logic               tz_lock;
      logic               ns_en;
      logic               user_en;
      logic               cfg_lock;
   } wag_ctrl_t;

   function automatic logic [CW_W-1:0] wag_pack(input wag_ctrl_t c);
      logic [CW_W-1:0] w;
      w = '0;
      w[ALLOW_LSB +: ALLOW_W] = c.allow;
      w[LIST_LOCK_BIT]        = c.list_lock;
      w[TZ_LOCK_BIT]          = c.tz_lock;
      w[NS_EN_BIT]            = c.ns_en;
      w[USER_EN_BIT]          = c.user_en;
      w[CFG_LOCK_BIT]         = c.cfg_lock;
      return w;
   endfunction
endpackage

// File: rtl/wag_ctrl_reg.sv
`timescale 1ns/1ps
module wag_ctrl_reg
   import wag_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [CW_W-1:0] wdata,
   output wag_ctrl_t       q
);
   // each field group is writable only while its own lock is still open
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         if (!q.tz_lock) begin
            q.tz_lock <= wdata[TZ_LOCK_BIT];
            q.ns_en   <= wdata[NS_EN_BIT];
            q.user_en <= wdata[USER_EN_BIT];
         end
         if (!q.list_lock) begin
            q.list_lock <= wdata[LIST_LOCK_BIT];
            q.allow     <= wdata[ALLOW_LSB +: ALLOW_W];
         end
         if (!q.cfg_lock) begin
            q.cfg_lock <= wdata[CFG_LOCK_BIT];
         end
      end
   end
endmodule

// File: rtl/wag_bank.sv
`timescale 1ns/1ps
module wag_bank #(
   parameter int unsigned          N_WORDS   = 8,
   parameter int unsigned          DATA_W    = 32,
   parameter int unsigned          IW        = 3,
   parameter logic [N_WORDS-1:0]   PROT_MASK = '0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [IW-1:0]               widx,
   input  logic [DATA_W-1:0]           wdata,
   input  logic                        cfg_lock,
   output logic [N_WORDS*DATA_W-1:0]   words,
   output logic                        frozen_hit
);
   logic [N_WORDS-1:0] frozen;

   for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_word
      logic              hit;
      logic [DATA_W-1:0] word_q;
      assign hit = (widx == IW'(gi));
      if (PROT_MASK[gi]) begin : g_prot
         assign frozen[gi] = hit & cfg_lock;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        word_q <= '0;
            else if (we && hit && !cfg_lock)   word_q <= wdata;
         end
      end else begin : g_open
         assign frozen[gi] = 1'b0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          word_q <= '0;
            else if (we && hit)  word_q <= wdata;
         end
      end
      assign words[gi*DATA_W +: DATA_W] = word_q;
   end

   assign frozen_hit = |frozen;
endmodule

// File: rtl/wag_policy.sv
`timescale 1ns/1ps
module wag_policy
   import wag_pkg::*;
#(
   parameter int unsigned AW      = 4,
   parameter int unsigned DOM_W   = 4,
   parameter int unsigned N_WORDS = 8,
   parameter int unsigned IW      = 3
) (
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DOM_W-1:0] wr_dom,
   input  logic             wr_priv,
   input  logic             wr_sec,
   input  wag_ctrl_t        ctrl,
   input  logic             frozen_hit,
   output logic             ctrl_we,
   output logic             bank_we,
   output logic [IW-1:0]    bank_idx,
   output logic             grant_d,
   output logic             err_d
);
   logic mode_ok, dom_ok, is_ctrl, in_bank;
   logic [AW-1:0] idx_full;

   always_comb begin
      mode_ok  = (wr_priv | ctrl.user_en) & (wr_sec | ctrl.ns_en);
      dom_ok   = ctrl.allow[wr_dom];
      is_ctrl  = (wr_addr == '0);
      in_bank  = !is_ctrl && (wr_addr <= AW'(N_WORDS));
      idx_full = wr_addr - AW'(1);
      bank_idx = idx_full[IW-1:0];
      ctrl_we  = wr_en & is_ctrl & mode_ok;
      bank_we  = wr_en & in_bank & mode_ok & dom_ok & !frozen_hit;
      grant_d  = ctrl_we | bank_we;
      err_d    = wr_en & !(ctrl_we | bank_we);
   end
endmodule

// File: rtl/wr_auth_gate.sv
`timescale 1ns/1ps
module wr_auth_gate
   import wag_pkg::*;
#(
   parameter int unsigned        N_WORDS   = 8,
   parameter int unsigned        DOM_W     = 4,
   parameter int unsigned        AW        = $clog2(N_WORDS + 1),
   parameter logic [N_WORDS-1:0] PROT_MASK = 8'h0F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [31:0]      wr_data,
   input  logic [DOM_W-1:0] wr_dom,
   input  logic             wr_priv,
   input  logic             wr_sec,
   input  logic [AW-1:0]    rd_addr,
   output logic [31:0]      rd_data,
   output logic             wr_grant,
   output logic             wr_err
);
   localparam int unsigned DATA_W = CW_W;
   localparam int unsigned IW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

   if ((1 << DOM_W) != ALLOW_W) begin : g_bad_dom
      $error("DOM_W must address exactly the allow-list width");
   end
   if (AW < $clog2(N_WORDS + 1)) begin : g_bad_aw
      $error("AW too narrow for policy word plus bank");
   end
   if (N_WORDS < 2) begin : g_bad_n
      $error("N_WORDS must be at least 2");
   end

   wag_ctrl_t                 ctrl_q;
   logic [DATA_W-1:0]         ctrl_word;
   logic [N_WORDS*DATA_W-1:0] words;
   logic                      frozen_hit, ctrl_we, bank_we, grant_d, err_d;
   logic [IW-1:0]             bank_idx;

   wag_policy #(.AW(AW), .DOM_W(DOM_W), .N_WORDS(N_WORDS), .IW(IW)) policy_i (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_dom(wr_dom), .wr_priv(wr_priv),
      .wr_sec(wr_sec), .ctrl(ctrl_q), .frozen_hit(frozen_hit),
      .ctrl_we(ctrl_we), .bank_we(bank_we), .bank_idx(bank_idx),
      .grant_d(grant_d), .err_d(err_d)
   );

   wag_ctrl_reg ctrl_i (
      .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(wr_data), .q(ctrl_q)
   );

   wag_bank #(.N_WORDS(N_WORDS), .DATA_W(DATA_W), .IW(IW), .PROT_MASK(PROT_MASK)) bank_i (
      .clk(clk), .rst_n(rst_n), .we(bank_we), .widx(bank_idx), .wdata(wr_data),
      .cfg_lock(ctrl_q.cfg_lock), .words(words), .frozen_hit(frozen_hit)
   );

   assign ctrl_word = wag_pack(ctrl_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_grant <= 1'b0;
         wr_err   <= 1'b0;
      end else begin
         wr_grant <= grant_d;
         wr_err   <= err_d;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == '0) rd_data = ctrl_word;
      for (int i = 0; i < N_WORDS; i++) begin
         if (rd_addr == AW'(i + 1)) rd_data = words[i*DATA_W +: DATA_W];
      end
   end
endmodule

// File: rtl/wag_chk.sv
`timescale 1ns/1ps
module wag_chk #(
   parameter int unsigned AW      = 4,
   parameter int unsigned DOM_W   = 4,
   parameter int unsigned N_WORDS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [AW-1:0]    wr_addr,
   input logic [DOM_W-1:0] wr_dom,
   input logic             wr_priv,
   input logic             wr_sec,
   input logic             wr_grant,
   input logic             wr_err,
   input logic [31:0]      ctrl_word
);
   p_resp_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_grant && wr_err));

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!wr_grant && !wr_err));

   p_deny_dom_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr != '0 && wr_addr <= AW'(N_WORDS) && !ctrl_word[16 + wr_dom]) |=> wr_err);

   p_deny_user_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_priv && !ctrl_word[8]) |=> wr_err);

   p_deny_ns_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sec && !ctrl_word[9]) |=> wr_err);

   p_tz_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[11] |=> $stable({ctrl_word[11], ctrl_word[9:8]}));

   p_list_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[15] |=> $stable(ctrl_word[31:15]));

   p_cfg_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_word[7] |=> ctrl_word[7]);

   p_ctrl_needs_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ctrl_word) |-> ($past(wr_en) && $past(wr_addr) == '0 && wr_grant));
endmodule

bind wr_auth_gate wag_chk #(.AW(AW), .DOM_W(DOM_W), .N_WORDS(N_WORDS)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_dom(wr_dom),
   .wr_priv(wr_priv), .wr_sec(wr_sec), .wr_grant(wr_grant), .wr_err(wr_err),
   .ctrl_word(ctrl_word)
);

// File: tb/wr_auth_gate_tb_top.sv
`timescale 1ns/1ps
module wr_auth_gate_tb_top;
   localparam int N  = 8;
   localparam int AW = 4;
   localparam logic [N-1:0] PROT = 8'h0F;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, wr_priv = 1'b0, wr_sec = 1'b0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_dom = '0;
   logic [31:0] rd_data;
   logic wr_grant, wr_err;

   int  n_run = 0, n_fail = 0;
   bit  done = 1'b0;
   logic [31:0] m_ctrl;
   logic [31:0] m_bank [N];

   always #2.5 clk = ~clk;

   wr_auth_gate #(.N_WORDS(N), .DOM_W(4), .AW(AW), .PROT_MASK(PROT)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_dom(wr_dom), .wr_priv(wr_priv), .wr_sec(wr_sec), .rd_addr(rd_addr),
      .rd_data(rd_data), .wr_grant(wr_grant), .wr_err(wr_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input int a);
      if (a == 0) return m_ctrl;
      if (a <= N) return m_bank[a-1];
      return 32'h0;
   endfunction

   // expected outcome from the requirements; updates the model on acceptance
   function automatic bit m_apply(input int a, input logic [31:0] d, input int dom,
                                  input bit pv, input bit sc);
      bit mode_ok;
      mode_ok = (pv || m_ctrl[8]) && (sc || m_ctrl[9]);
      if (a == 0) begin
         if (!mode_ok) return 1'b0;
         if (!m_ctrl[11]) begin m_ctrl[11] = d[11]; m_ctrl[9] = d[9]; m_ctrl[8] = d[8]; end
         if (!m_ctrl[15]) begin m_ctrl[15] = d[15]; m_ctrl[31:16] = d[31:16]; end
         if (!m_ctrl[7])  m_ctrl[7] = d[7];
         return 1'b1;
      end
      if (a > N) return 1'b0;
      if (!mode_ok || !m_ctrl[16+dom] || (m_ctrl[7] && PROT[a-1])) return 1'b0;
      m_bank[a-1] = d;
      return 1'b1;
   endfunction

   task automatic rd_chk(input int a, input string req);
      rd_addr = AW'(a);
      #1;
      chk(rd_data === m_read(a), req, $sformatf("read addr %0d", a), rd_data, m_read(a));
   endtask

   task automatic do_wr(input int a, input logic [31:0] d, input int dom,
                        input bit pv, input bit sc, input string req);
      bit g;
      g = m_apply(a, d, dom, pv, sc);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_dom = 4'(dom);
      wr_priv = pv; wr_sec = sc;
      @(negedge clk);
      wr_en = 1'b0;
      chk(wr_grant === g,  req, "grant", {31'b0, wr_grant}, {31'b0, g});
      chk(wr_err   === !g, req, "err",   {31'b0, wr_err},   {31'b0, !g});
      rd_chk((a <= N) ? a : 0, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0001));
      m_ctrl = '0;
      for (int i = 0; i < N; i++) m_bank[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(wr_grant === 1'b0, "R1", "grant after reset", {31'b0, wr_grant}, 32'h0);
      chk(wr_err === 1'b0,   "R1", "err after reset",   {31'b0, wr_err},   32'h0);
      for (int a = 0; a <= N; a++) rd_chk(a, "R1");

      // R8: open policy write from privileged secure requester
      do_wr(0, 32'h0008_0000, 0, 1, 1, "R8");
      // R2: admitted and refused domains
      do_wr(1, 32'hA5A5_0001, 3, 1, 1, "R2");
      do_wr(1, 32'hDEAD_BEEF, 5, 1, 1, "R2");
      // R3 / R4: user and non-secure refused, bank and policy word alike
      do_wr(2, 32'h0000_1111, 3, 0, 1, "R3");
      do_wr(2, 32'h0000_1112, 3, 1, 0, "R4");
      do_wr(0, 32'hFFFF_0000, 3, 0, 1, "R3");
      do_wr(0, 32'hFFFF_0000, 3, 1, 0, "R4");
      // R3 / R4: enables admit user non-secure writers
      do_wr(0, 32'h0008_0300, 0, 1, 1, "R3");
      do_wr(2, 32'h0000_2222, 3, 0, 0, "R4");
      // R9 / R10: out-of-range
      do_wr(9, 32'h1234_5678, 3, 1, 1, "R9");
      rd_chk(12, "R10");
      @(negedge clk);
      chk(!wr_grant && !wr_err, "R9", "idle cycle quiet", {30'b0, wr_grant, wr_err}, 32'h0);

      // random phase, lock bits held clear (R2 R3 R4 R8 R10)
      for (int k = 0; k < 400; k++) begin
         int a; logic [31:0] d;
         a = int'($urandom_range(0, 11));
         d = $urandom;
         if (a == 0) d = d & ~32'h0000_8880;
         do_wr(a, d, int'($urandom_range(0, 15)), bit'($urandom % 2), bit'($urandom % 2), "R8");
         rd_chk(int'($urandom_range(0, 15)), "R10");
      end
      do_wr(0, 32'h00FF_0300, 0, 1, 1, "R8");

      // R6: lock and new list in the same write
      do_wr(0, 32'h00FF_8300, 0, 1, 1, "R6");
      rd_addr = '0; #1;
      chk(rd_data === 32'h00FF_8300, "R6", "lock+list same write", rd_data, 32'h00FF_8300);
      do_wr(0, 32'hFFFF_0300, 0, 1, 1, "R6");
      rd_addr = '0; #1;
      chk(rd_data === 32'h00FF_8300, "R6", "list frozen", rd_data, 32'h00FF_8300);
      do_wr(3, 32'h0000_3333, 9, 1, 1, "R2");

      // R5: trust lock with enables in the same write
      do_wr(0, 32'h0000_0A00, 0, 1, 1, "R5");
      rd_addr = '0; #1;
      chk(rd_data === 32'h00FF_8A00, "R5", "tz lock applied", rd_data, 32'h00FF_8A00);
      do_wr(0, 32'h0000_0100, 0, 1, 1, "R5");
      rd_addr = '0; #1;
      chk(rd_data === 32'h00FF_8A00, "R5", "tz fields frozen", rd_data, 32'h00FF_8A00);
      do_wr(4, 32'h0000_4444, 3, 0, 1, "R5");
      do_wr(4, 32'h0000_4445, 3, 1, 0, "R5");

      // R7: configuration lock freezes protected words only
      do_wr(0, 32'h0000_0080, 0, 1, 1, "R7");
      do_wr(1, 32'h7777_0001, 3, 1, 1, "R7");
      do_wr(6, 32'h7777_0006, 3, 1, 1, "R7");
      do_wr(0, 32'h0000_0000, 0, 1, 1, "R7");
      rd_addr = '0; #1;
      chk(rd_data === 32'h00FF_8A80, "R7", "all locks held", rd_data, 32'h00FF_8A80);
      @(negedge clk);
      chk(!wr_grant && !wr_err, "R9", "pulse one cycle", {30'b0, wr_grant, wr_err}, 32'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule